// File: doc/BRIEF.md
# Mode-Decoded Serial Audio Clock Generator

This block takes a four-bit strap code and turns it into the clocking setup of a serial audio port. The code selects, all at once, whether the port drives its own clocks (master role) or follows clocks from outside (slave role). It also sets the speed class, whether the converter's DC-blocking filter is on, and which serial framing convention the data path uses. The decoded fields leave the block as plain status outputs, so neighbouring logic can act on them.

In a master code the block divides the system clock into a bit clock and a frame clock. The frame clock runs at the sample rate and the bit clock at 64 times that rate. The system-clock-to-sample-rate ratio that the code names sets the divide factor of the bit clock. In a slave code, and while the active-low power-down input is low, both generated clocks stay low and both dividers are held at zero. When the block leaves that state, the first frame it produces is a complete one.

Top module: `mode_clock_divider`

## Requirements
- R1: `is_master` is 1 for codes 12 to 15 and 0 for codes 0 to 11.
- R2: In a master code, `speed` and the bit clock period (in system clocks) are: code 12 gives double speed (`speed`=1), ratio 256, period 4; code 13 gives normal speed (`speed`=0), ratio 512, period 8; code 14 gives quad speed (`speed`=2), ratio 128, period 2; code 15 gives normal speed (`speed`=0), ratio 256, period 4.
- R3: `hpf_en` is 1 for every master code and for every slave code whose bits [1:0] are 00 or 01. It is 0 for slave codes whose bits [1:0] are 10 or 11.
- R4: `fmt` is 0 (mixed left/right-justified) for codes 0 to 3, 1 (I2S) for codes 4 to 7 and 12 to 15, and 2 (left-justified) for codes 8 to 11. The value 3 never appears.
- R5: In a slave code, `speed` comes from bits [1:0]: 00 gives quad (2), 01 gives double (1), 10 and 11 give normal (0).
- R6: In a slave code, `bit_clk` and `frame_clk` are low from the first system clock edge after the code is applied. Switching into a slave code discards any divider state.
- R7: In a master code, `bit_clk` has a 50% duty cycle of h high and h low system clocks, where h is half the R2 period. It first rises at the h-th system clock edge after the divider starts running.
- R8: `frame_clk` starts low and changes only at an edge where `bit_clk` falls. It changes on every 32nd such fall, so one frame lasts 64 bit clock periods.
- R9: While `pdn_n` is low, `bit_clk` and `frame_clk` are low and both dividers are cleared. After `pdn_n` rises, counting restarts from zero, so the first frame is full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (oversampling) clock |
| pdn_n | input | 1 | Active-low power-down; asynchronously clears the dividers |
| mode | input | 4 | Strap code selecting role, ratio, filter and format |
| bit_clk | output | 1 | Generated serial bit clock (master codes only) |
| frame_clk | output | 1 | Generated frame clock at the sample rate (master codes only) |
| is_master | output | 1 | 1 when the code selects the master role |
| speed | output | 2 | Speed class: 0 normal, 1 double, 2 quad |
| hpf_en | output | 1 | DC-blocking filter enable |
| fmt | output | 2 | Framing: 0 mixed left/right-justified, 1 I2S, 2 left-justified |

## Verification
The event most likely to go wrong is the frame clock edge that falls in the same system clock cycle as a bit clock falling edge. The frame divider must advance on exactly the edge the bit divider reports, not one cycle before or after it. The bench runs every master code long enough to cover several frame edges at each divide factor. A closed-form reference compares both clocks on every cycle and flags any frame change that is not aligned with a bit-clock fall. A second collision comes from power-down or a slave code arriving in the middle of a frame. The bench applies both part-way through a frame and checks that the clocks drop at once and that the next frame starts from zero.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2
   } speed_e;

   typedef enum logic [1:0] {
      FMT_MIXED = 2'd0,
      FMT_I2S   = 2'd1,
      FMT_LJ    = 2'd2
   } fmt_e;

   // log2 of the bit clock half period in system clocks
   localparam int HALF_LOG_MAX = 2;
   localparam int HALF_LOG_W   = $clog2(HALF_LOG_MAX + 1);

   typedef struct packed {
      logic                  master;
      speed_e                speed;
      logic                  hpf;
      fmt_e                  fmt;
      logic [HALF_LOG_W-1:0] half_log;
   } mode_dec_t;

endpackage

// File: rtl/mcd_mode_decode.sv
module mcd_mode_decode
   import mcd_pkg::*;
#(
   parameter int MODE_W = 4
) (
   input  logic [MODE_W-1:0] mode,
   output mode_dec_t         dec
);

   if (MODE_W != 4) begin : g_bad_width
      $error("mcd_mode_decode: MODE_W must be 4");
   end

   logic [1:0] grp;
   logic [1:0] sub;

   assign grp = mode[3:2];
   assign sub = mode[1:0];

   always_comb begin
      dec          = '0;
      dec.master   = (grp == 2'b11);
      dec.hpf      = dec.master | ~sub[1];

      unique case (grp)
         2'b00:   dec.fmt = FMT_MIXED;
         2'b10:   dec.fmt = FMT_LJ;
         default: dec.fmt = FMT_I2S;
      endcase

      if (dec.master) begin
         unique case (sub)
            2'b00: begin dec.speed = SPD_DOUBLE; dec.half_log = HALF_LOG_W'(1); end
            2'b01: begin dec.speed = SPD_NORMAL; dec.half_log = HALF_LOG_W'(2); end
            2'b10: begin dec.speed = SPD_QUAD;   dec.half_log = HALF_LOG_W'(0); end
            default: begin dec.speed = SPD_NORMAL; dec.half_log = HALF_LOG_W'(1); end
         endcase
      end else begin
         unique case (sub)
            2'b00:   dec.speed = SPD_QUAD;
            2'b01:   dec.speed = SPD_DOUBLE;
            default: dec.speed = SPD_NORMAL;
         endcase
         dec.half_log = '0;
      end
   end

endmodule

// File: rtl/mcd_bit_div.sv
module mcd_bit_div
   import mcd_pkg::*;
#(
   parameter int LOG_MAX = HALF_LOG_MAX
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [HALF_LOG_W-1:0] half_log,
   output logic                  bclk,
   output logic                  fall_stb
);

   localparam int CW = (LOG_MAX > 0) ? LOG_MAX : 1;

   if (LOG_MAX < 0 || LOG_MAX > 8) begin : g_bad_log
      $error("mcd_bit_div: LOG_MAX out of range");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic          wrap;

   assign lim      = CW'((32'd1 << half_log) - 32'd1);
   assign wrap     = run && (cnt_q >= lim);
   assign fall_stb = wrap && bclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bclk  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         bclk  <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         bclk  <= ~bclk;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R7
   bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && half_log != '0 && $rose(bclk)) |=> (bclk || !run));

endmodule

// File: rtl/mcd_frame_div.sv
module mcd_frame_div #(
   parameter int HALF_BCLKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fall_stb,
   input  logic bclk,
   output logic frame
);

   localparam int  BW     = (HALF_BCLKS > 1) ? $clog2(HALF_BCLKS) : 1;
   localparam bit  IS_POW = (HALF_BCLKS > 1) && ((1 << BW) == HALF_BCLKS);

   if (HALF_BCLKS < 2) begin : g_bad_half
      $error("mcd_frame_div: HALF_BCLKS must be at least 2");
   end

   logic [BW-1:0] bits_q;
   logic          last;

   if (IS_POW) begin : g_pow2
      assign last = &bits_q;
   end else begin : g_cmp
      assign last = (bits_q == BW'(HALF_BCLKS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         frame  <= 1'b0;
      end else if (!run) begin
         bits_q <= '0;
         frame  <= 1'b0;
      end else if (fall_stb) begin
         if (last) begin
            bits_q <= '0;
            frame  <= ~frame;
         end else begin
            bits_q <= bits_q + BW'(1);
         end
      end
   end

   // R8
   frame_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(frame)) |-> $fell(bclk));

endmodule

// File: rtl/mode_clock_divider.sv
module mode_clock_divider
   import mcd_pkg::*;
#(
   parameter int MODE_W           = 4,
   parameter int FRAME_HALF_BCLKS = 32
) (
   input  logic              sys_clk,
   input  logic              pdn_n,
   input  logic [MODE_W-1:0] mode,
   output logic              bit_clk,
   output logic              frame_clk,
   output logic              is_master,
   output logic [1:0]        speed,
   output logic              hpf_en,
   output logic [1:0]        fmt
);

   mode_dec_t dec;
   logic      fall_stb;

   mcd_mode_decode #(.MODE_W(MODE_W)) i_dec (
      .mode (mode),
      .dec  (dec)
   );

   mcd_bit_div #(.LOG_MAX(HALF_LOG_MAX)) i_bdiv (
      .clk      (sys_clk),
      .rst_n    (pdn_n),
      .run      (dec.master),
      .half_log (dec.half_log),
      .bclk     (bit_clk),
      .fall_stb (fall_stb)
   );

   mcd_frame_div #(.HALF_BCLKS(FRAME_HALF_BCLKS)) i_fdiv (
      .clk      (sys_clk),
      .rst_n    (pdn_n),
      .run      (dec.master),
      .fall_stb (fall_stb),
      .bclk     (bit_clk),
      .frame    (frame_clk)
   );

   assign is_master = dec.master;
   assign speed     = dec.speed;
   assign hpf_en    = dec.hpf;
   assign fmt       = dec.fmt;

   // R6
   slave_idle_chk: assert property (@(posedge sys_clk) disable iff (!pdn_n)
      !is_master |=> (!bit_clk && !frame_clk));

   // R3
   master_hpf_chk: assert property (@(posedge sys_clk) disable iff (!pdn_n)
      is_master |-> hpf_en);

   // R4
   code_legal_chk: assert property (@(posedge sys_clk) disable iff (!pdn_n)
      (fmt != 2'd3) && (speed != 2'd3));

   // R9
   pdn_hold_chk: assert property (@(posedge sys_clk)
      (!pdn_n && $past(!pdn_n)) |-> (!bit_clk && !frame_clk));

endmodule

// File: tb/test_mode_clock_divider.sv
`timescale 1ns/1ps
module test_mode_clock_divider;

   logic       sys_clk = 1'b0;
   logic       pdn_n   = 1'b0;
   logic [3:0] mode    = 4'd13;
   logic       bit_clk, frame_clk, is_master, hpf_en;
   logic [1:0] speed, fmt;

   int total = 0;
   int bad   = 0;
   int n     = 0;

   always #2.5 sys_clk = ~sys_clk;

   mode_clock_divider i_mode_clock_divider (
      .sys_clk   (sys_clk),
      .pdn_n     (pdn_n),
      .mode      (mode),
      .bit_clk   (bit_clk),
      .frame_clk (frame_clk),
      .is_master (is_master),
      .speed     (speed),
      .hpf_en    (hpf_en),
      .fmt       (fmt)
   );

   function automatic int half_of(input logic [3:0] m);
      case (m)
         4'd12: return 2;   // ratio 256
         4'd13: return 4;   // ratio 512
         4'd14: return 1;   // ratio 128
         default: return 2; // 15, ratio 256
      endcase
   endfunction

   // reference: count of edges since the divider started running
   always @(posedge sys_clk) begin
      if (pdn_n && mode >= 4'd12) n <= n + 1;
      else n <= 0;
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s mode=%0d pdn_n=%0b actual=%0d expected=%0d at %0t",
                  tag, mode, pdn_n, act, exp, $time);
      end
   endtask

   always @(negedge sys_clk) begin
      int  h, eb, ef, es, ex;
      bit  m;
      m  = (mode >= 4'd12);
      h  = half_of(mode);
      eb = m ? ((n / h) % 2) : 0;
      ef = m ? ((n / (64 * h)) % 2) : 0;
      check("R1 role", is_master, m);
      check("R3 filter", hpf_en, (m || mode[1] == 1'b0) ? 1 : 0);
      ex = (mode < 4) ? 0 : (mode < 8) ? 1 : (mode < 12) ? 2 : 1;
      check("R4 format", fmt, ex);
      if (m) es = (mode == 12) ? 1 : (mode == 14) ? 2 : 0;
      else   es = (mode[1:0] == 2'b00) ? 2 : (mode[1:0] == 2'b01) ? 1 : 0;
      check(m ? "R2 speed" : "R5 speed", speed, es);
      if (!pdn_n) begin
         check("R9 bit_clk", bit_clk, 0);
         check("R9 frame_clk", frame_clk, 0);
      end else if (!m) begin
         check("R6 bit_clk", bit_clk, 0);
         check("R6 frame_clk", frame_clk, 0);
      end else begin
         check("R7 bit_clk", bit_clk, eb);
         check("R8 frame_clk", frame_clk, ef);
      end
   end

   task automatic step(input int cnt);
      repeat (cnt) @(negedge sys_clk);
      #1;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // reset state, R9
      step(3);
      pdn_n = 1'b1;
      // decode sweep over slave codes, R1 R3 R4 R5 R6
      for (int c = 0; c < 12; c++) begin
         mode = c[3:0];
         step(4);
      end
      // each master code from power-down, R2 R7 R8
      for (int c = 12; c < 16; c++) begin
         pdn_n = 1'b0;
         mode  = c[3:0];
         step(3);
         pdn_n = 1'b1;
         step(64 * 2 * half_of(c[3:0]) * 2 + 37);
      end
      // power-down in the middle of a frame, then restart, R9
      step(100);
      pdn_n = 1'b0;
      step(5);
      pdn_n = 1'b1;
      step(600);
      // master to slave mid-frame, then back, R6
      mode = 4'd9;
      step(20);
      mode = 4'd14;
      step(400);
      mode = 4'd2;
      step(10);
      mode = 4'd12;
      step(700);
      finish_run();
   end

endmodule